// File: doc/BRIEF.md
# Error Frequency Mute Detector

This block watches the uncorrectable-error flags that a block decoder raises, one pulse for each codeword it cannot repair. It totals those pulses over a run of frames whose length software picks. At the end of each run it compares the total against two levels that both derive from the most errors the run could hold, which is 32 per frame. A total above the upper level asks for the audio path to be muted. The request is withdrawn only after a later run whose total lies below the lower level, which is exactly half the upper one. Totals between the two levels leave the request as it was, so the output does not chatter near one threshold.

The decision is a two-state machine. In `ST_CLEAR` no mute is requested. The ARM transition to `ST_MUTED` happens at a run end whose total exceeds the mute level. The RELEASE transition back to `ST_CLEAR` happens at a run end whose total is below the cancel level. Every other cycle takes the HOLD transition, which keeps the current state. An enable input masks the request at the output. The counting and the state machine go on working while the request is masked, so raising the enable again shows the state that the error rate has earned by then.

Top module: `emfd_error_mute`

## Requirements
- R1: After reset, `mute` is 0, the machine is in `ST_CLEAR`, and both the error total and the frame position are zero.
- R2: The run length is F = BASE_FRAMES << `win_sel`. With the default BASE_FRAMES of 128 the codes are 0→128, 1→256, 2→512 and 3→1024 frames. A run closes on the F-th `frame_tick` after the previous close or after reset.
- R3: The mute level is (ERRS_PER_FRAME·F) >> (`thr_sel`+1). With ERRS_PER_FRAME of 32 the codes are 0→1/2, 1→1/4, 2→1/8 and 3→1/16 of the run maximum. When the machine is in `ST_CLEAR` and a run closes with a total strictly greater than this level, `mute` is 1 from the cycle after the closing strobe.
- R4: The cancel level is (ERRS_PER_FRAME·F) >> (`thr_sel`+2), which is half the mute level. When the machine is in `ST_MUTED` and a run closes with a total strictly below this level, `mute` returns to 0 from the cycle after the closing strobe.
- R5: A run total equal to the mute level does not arm the machine. A run total equal to the cancel level does not release it.
- R6: The state changes only on the closing strobe of a run. `mute` stays constant across the strobes inside a run while the enable is steady.
- R7: The error total is CNT_W bits wide, 16 by default. It saturates at its all-ones value and does not wrap.
- R8: The total and the frame position return to zero after each closing strobe. An error pulse in the same cycle as a closing strobe counts toward the run that is closing.
- R9: While `enable` is 0, `mute` is 0 from the next cycle on. Counting and state tracking continue while the output is masked, and `mute` shows the tracked state one cycle after `enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| dbl_err | input | 1 | One-cycle pulse per uncorrectable codeword |
| win_sel | input | SEL_W | Run-length code |
| thr_sel | input | SEL_W | Threshold-ratio code |
| enable | input | 1 | 1 lets the request reach `mute` |
| mute | output | 1 | Registered mute request |

## Verification
A run decision appears on `mute` one cycle after the closing `frame_tick`, because the state and the output register both load on that edge. The bench therefore drives each input just after a falling edge and reads `mute` at the next falling edge, after the strobe's rising edge. Enable changes take effect one edge later and are read in the same way. Before each closing strobe the bench also reads `mute` after the F-1 inner strobes, to show that nothing moves inside a run. It then reads again right after the closing strobe. For every pair of `win_sel` and `thr_sel`, the bench computes the two levels arithmetically and places the totals exactly on them and one away from them.

// File: rtl/emfd_pkg.sv
package emfd_pkg;

    // Decision state of the mute detector.
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_MUTED = 1'b1
    } mute_state_t;

endpackage

// File: rtl/emfd_frame_timer.sv
module emfd_frame_timer #(
    parameter int BASE_FRAMES = 128,
    parameter int SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic [SEL_W-1:0] win_sel,
    output logic             win_end
);
    localparam int MAX_FRAMES = BASE_FRAMES * (2 ** ((2 ** SEL_W) - 1));
    localparam int POS_W      = $clog2(MAX_FRAMES);

    logic [POS_W-1:0] pos_q;
    logic [POS_W:0]   run_len;
    logic [POS_W:0]   last_pos;

    always_comb begin
        run_len  = (POS_W+1)'(BASE_FRAMES) << win_sel;
        last_pos = run_len - 1'b1;
        // A shorter run chosen mid-way closes at the next strobe.
        win_end  = frame_tick && ({1'b0, pos_q} >= last_pos);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (frame_tick) begin
            pos_q <= win_end ? '0 : pos_q + 1'b1;
        end
    end

    // R8: position restarts after a closing strobe
    p_pos_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (pos_q == '0));

    // R2: each inner strobe advances the position by one
    p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !win_end) |=> (pos_q == $past(pos_q) + 1'b1));

    // R2: without a strobe the position is frozen
    p_pos_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(pos_q));

endmodule

// File: rtl/emfd_err_counter.sv
module emfd_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err,
    input  logic             clr,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt_q;

    // The running total includes a pulse arriving in this cycle.
    always_comb begin
        if (err && (cnt_q != {CNT_W{1'b1}})) begin
            total = cnt_q + 1'b1;
        end else begin
            total = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= clr ? '0 : total;
        end
    end

    // R8: the total is empty after a run closes
    p_clear_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R7: inside a run the total never goes down (no wrap)
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));

    // R7: a full counter stays full until the run closes
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == {CNT_W{1'b1}}) && !clr) |=> (cnt_q == {CNT_W{1'b1}}));

endmodule

// File: rtl/emfd_thresholds.sv
module emfd_thresholds #(
    parameter int ERRS_PER_FRAME = 32,
    parameter int BASE_FRAMES    = 128,
    parameter int SEL_W          = 2,
    parameter int LVL_W          = 16
) (
    input  logic [SEL_W-1:0] win_sel,
    input  logic [SEL_W-1:0] thr_sel,
    output logic [LVL_W-1:0] mute_lvl,
    output logic [LVL_W-1:0] cancel_lvl
);
    logic [LVL_W-1:0] run_max;
    logic [SEL_W:0]   mute_sh;

    always_comb begin
        run_max    = LVL_W'(ERRS_PER_FRAME * BASE_FRAMES) << win_sel;
        mute_sh    = {1'b0, thr_sel} + 1'b1;
        mute_lvl   = run_max >> mute_sh;
        cancel_lvl = run_max >> (mute_sh + 1'b1);
    end

endmodule

// File: rtl/emfd_error_mute.sv
module emfd_error_mute #(
    parameter int ERRS_PER_FRAME = 32,
    parameter int BASE_FRAMES    = 128,
    parameter int SEL_W          = 2,
    parameter int CNT_W          = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             dbl_err,
    input  logic [SEL_W-1:0] win_sel,
    input  logic [SEL_W-1:0] thr_sel,
    input  logic             enable,
    output logic             mute
);
    import emfd_pkg::*;

    localparam int MAX_FRAMES = BASE_FRAMES * (2 ** ((2 ** SEL_W) - 1));
    localparam int LVL_W      = $clog2(ERRS_PER_FRAME * MAX_FRAMES + 1);
    localparam int CMP_W      = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic             win_end;
    logic [CNT_W-1:0] total;
    logic [LVL_W-1:0] mute_lvl;
    logic [LVL_W-1:0] cancel_lvl;
    logic [CMP_W-1:0] total_x;
    logic [CMP_W-1:0] mute_x;
    logic [CMP_W-1:0] cancel_x;
    logic             excess;
    logic             shortfall;

    mute_state_t state_q;
    mute_state_t state_d;
    logic        mute_q;

    emfd_frame_timer #(
        .BASE_FRAMES (BASE_FRAMES),
        .SEL_W       (SEL_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .win_sel    (win_sel),
        .win_end    (win_end)
    );

    emfd_err_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .err   (dbl_err),
        .clr   (win_end),
        .total (total)
    );

    emfd_thresholds #(
        .ERRS_PER_FRAME (ERRS_PER_FRAME),
        .BASE_FRAMES    (BASE_FRAMES),
        .SEL_W          (SEL_W),
        .LVL_W          (LVL_W)
    ) u_levels (
        .win_sel    (win_sel),
        .thr_sel    (thr_sel),
        .mute_lvl   (mute_lvl),
        .cancel_lvl (cancel_lvl)
    );

    always_comb begin
        total_x   = CMP_W'(total);
        mute_x    = CMP_W'(mute_lvl);
        cancel_x  = CMP_W'(cancel_lvl);
        excess    = total_x > mute_x;
        shortfall = total_x < cancel_x;
    end

    // Next-state logic: ARM, RELEASE or HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (win_end && excess)    state_d = ST_MUTED;
            ST_MUTED: if (win_end && shortfall) state_d = ST_CLEAR;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: the enable masks the request without stopping tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_q <= 1'b0;
        end else begin
            mute_q <= enable && (state_d == ST_MUTED);
        end
    end

    assign mute = mute_q;

    // R6: the state moves only on a closing strobe
    p_hold_inside_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(state_q));

    // R3: a closing total above the mute level arms the detector
    p_arm_on_excess_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && win_end && total_x > mute_x) |=> (state_q == ST_MUTED));

    // R4: a closing total below the cancel level releases it
    p_release_on_shortfall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && win_end && total_x < cancel_x) |=> (state_q == ST_CLEAR));

    // R9: a low enable silences the output on the next cycle
    p_masked_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mute);

endmodule

// File: tb/sim_emfd_error_mute.sv
module sim_emfd_error_mute;

    localparam int BASE = 4;
    localparam int EPF  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       dbl_err = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic [1:0] thr_sel = 2'd0;
    logic       enable = 1'b1;
    logic       mute;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_mute = 1'b0;

    always #4 clk = ~clk;

    emfd_error_mute #(
        .ERRS_PER_FRAME (EPF),
        .BASE_FRAMES    (BASE),
        .SEL_W          (2),
        .CNT_W          (16)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .dbl_err    (dbl_err),
        .win_sel    (win_sel),
        .thr_sel    (thr_sel),
        .enable     (enable),
        .mute       (mute)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic int frames_of(input int w);
        return BASE << w;
    endfunction

    function automatic int mute_level(input int w, input int t);
        return (EPF * frames_of(w)) >> (t + 1);
    endfunction

    function automatic int cancel_level(input int w, input int t);
        return (EPF * frames_of(w)) >> (t + 2);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_mute = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_errs(input int n);
        for (int i = 0; i < n; i++) begin
            dbl_err = 1'b1;
            @(negedge clk);
        end
        dbl_err = 1'b0;
    endtask

    task automatic strobe(input logic with_err);
        frame_tick = 1'b1;
        dbl_err    = with_err;
        @(negedge clk);
        frame_tick = 1'b0;
        dbl_err    = 1'b0;
    endtask

    // One run with n errors; model update from R3/R4/R5.
    task automatic run_window(input int w, input int t, input int n, input string req);
        int f;
        f = frames_of(w);
        pulse_errs(n);
        for (int k = 0; k < f - 1; k++) strobe(1'b0);
        @(negedge clk);
        chk(mute, exp_mute & enable, "R6", "unchanged before closing strobe");
        strobe(1'b0);
        if (!exp_mute && n > mute_level(w, t)) exp_mute = 1'b1;
        else if (exp_mute && n < cancel_level(w, t)) exp_mute = 1'b0;
        chk(mute, exp_mute & enable, req, $sformatf("after run w=%0d t=%0d n=%0d", w, t, n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk(mute, 1'b0, "R1", "mute after reset");

        // R2/R3/R4/R5 sweep over every window and threshold code.
        for (int w = 0; w < 4; w++) begin
            for (int t = 0; t < 4; t++) begin
                win_sel = 2'(w);
                thr_sel = 2'(t);
                do_reset();
                chk(mute, 1'b0, "R1", "mute after reset in sweep");
                run_window(w, t, mute_level(w, t), "R5");
                run_window(w, t, mute_level(w, t) + 1, "R3");
                run_window(w, t, cancel_level(w, t), "R5");
                run_window(w, t, cancel_level(w, t) - 1, "R4");
                run_window(w, t, cancel_level(w, t) + 2, "R2");
            end
        end

        // R8: a pulse on the closing strobe counts toward the closing run.
        win_sel = 2'd0;
        thr_sel = 2'd0;
        do_reset();
        pulse_errs(64);
        for (int k = 0; k < 3; k++) strobe(1'b0);
        strobe(1'b1);
        chk(mute, 1'b1, "R8", "coincident pulse counted (65 > 64)");
        exp_mute = 1'b1;
        run_window(0, 0, 0, "R8");

        // R7: 65546 errors saturate; a wrapping counter would read 10 and release.
        do_reset();
        run_window(0, 0, 100, "R3");
        run_window(0, 0, 65546, "R7");
        chk(mute, 1'b1, "R7", "saturated total keeps mute");
        run_window(0, 0, 0, "R4");

        // R9: masking and continued tracking.
        do_reset();
        enable = 1'b0;
        run_window(0, 0, 100, "R9");
        chk(mute, 1'b0, "R9", "masked while disabled");
        enable = 1'b1;
        @(negedge clk);
        chk(mute, 1'b1, "R9", "tracked state shown after enable");
        enable = 1'b0;
        @(negedge clk);
        chk(mute, 1'b0, "R9", "masked again");
        run_window(0, 0, 0, "R9");
        enable = 1'b1;
        @(negedge clk);
        chk(mute, 1'b0, "R9", "release tracked while disabled");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule